// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block turns single bus requests from a small controller core into cycles on an 8-bit multiplexed external memory bus. The core asks for a code fetch, a data read or a data write, together with an 18-bit address and, for writes, a data byte. The sequencer then produces the address latch pulse and the read, code and write strobes. It places the address and the data on two byte-wide ports in the arrangement that the selected bus mode needs. When the cycle ends it returns a one-cycle done pulse and, for reads, the captured byte.

Everything is counted in oscillator clocks, and one bus state lasts two clocks. The latch phase and the strobe phase each take programmed wait states. In page mode, a fetch that stays inside the 256-byte page of the fetch just before it skips the latch phase. The code strobe stays low through a chain of such fetches. An external ready input can stretch a strobe for as long as it is held low. A free-running wait clock at half the oscillator rate can be enabled. Two configuration bits choose whether the top address bits appear on pins and how the read and code strobes divide the address space.

Top module: `xbus_seq`

## Requirements
- R1: After reset, busy and done are low, the latch output is low, all three strobes are high, and neither port is driven.
- R2: In non-page mode, port 0 carries address bits 7:0 during the latch phase. During a write strobe it carries the write byte, and during a read strobe it is released. Port 2 carries address bits 15:8 for the whole cycle.
- R3: In page mode, port 0 carries address bits 7:0 for the whole cycle. Port 2 carries address bits 15:8 during the latch phase. During a write strobe it carries the write byte, and during a read strobe it is released.
- R4: The latch output is high for 2·(1+cfg_ale_ws) clocks and never overlaps a strobe.
- R5: A strobe is low for 2·(1+cfg_strb_ws) clocks, with cfg_strb_ws from 0 to 3. Only one strobe is low at a time.
- R6: In page mode, a page hit has no latch phase and takes only the strobe phase. A page hit is a fetch (req_kind 2'b00) whose address bits 17:8 equal those of the immediately preceding bus cycle, when that cycle was also a page-mode fetch. Any other request takes a latch phase.
- R7: When a page-hit fetch is presented in the done cycle of a fetch, the code strobe stays low without a gap until the last hit ends. It is high in the done cycle after the last hit.
- R8: With cfg_rtw_en set, wait_n low at the end of the programmed strobe count holds the strobe low until wait_n returns high. With cfg_rtw_en clear, wait_n has no effect.
- R9: With cfg_wclk_en set, wclk toggles on every clock. With it clear, wclk is low from the next clock on.
- R10: cfg_upper selects the upper-pin mode. 2'b00 drives a16 and a17 from address bits 16 and 17, and all reads use the code strobe. 2'b01 and 2'b10 drive a16 only, and all reads use the code strobe. 2'b11 drives neither pin, uses the read strobe when address bit 17 is 0 and the code strobe when it is 1. rd_n stays high in every mode except 2'b11.
- R11: busy is high from the clock after acceptance until the done cycle. done lasts one clock, and requests presented while busy are ignored.
- R12: For reads, rdata holds the value on the data port (port 0 in non-page mode, port 2 in page mode) from the last strobe clock, and it is valid from the done cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write |
| req_addr | input | 18 | Request address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Captured read byte |
| cfg_page | input | 1 | Page mode select |
| cfg_ale_ws | input | 1 | Latch-phase wait states |
| cfg_strb_ws | input | 2 | Strobe-phase wait states |
| cfg_rtw_en | input | 1 | Real-time wait enable |
| cfg_wclk_en | input | 1 | Wait clock enable |
| cfg_upper | input | 2 | Upper address pin mode |
| wait_n | input | 1 | Active-low external ready hold |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| psen_n | output | 1 | Code strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| p0_out | output | 8 | Port 0 output value |
| p0_oe | output | 1 | Port 0 drive enable |
| p0_in | input | 8 | Port 0 input value |
| p2_out | output | 8 | Port 2 output value |
| p2_oe | output | 1 | Port 2 drive enable |
| p2_in | input | 8 | Port 2 input value |
| a16 | output | 1 | Address bit 16 pin |
| a17 | output | 1 | Address bit 17 pin |
| wclk | output | 1 | Half-rate wait clock |

## Verification
The bench uses the default ADDR_W of 18, so bits 16 and 17 reach the upper pins and bit 17 is the region select for the split-strobe mode. The wait-state widths are configuration inputs, so one build covers the smallest and largest latch and strobe lengths: 2 and 4 clocks for the latch, 2 to 8 for the strobe. The same build also covers a ready hold that outlasts the programmed count, and one released early. Back-to-back fetches across a 256-byte boundary, and fetches after a data cycle, bring in both page-hit and page-miss timing.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata,
  input  logic              cfg_page,
  input  logic              cfg_ale_ws,
  input  logic [1:0]        cfg_strb_ws,
  input  logic              cfg_rtw_en,
  input  logic              cfg_wclk_en,
  input  logic [1:0]        cfg_upper,
  input  logic              wait_n,
  output logic              ale,
  output logic              rd_n,
  output logic              psen_n,
  output logic              wr_n,
  output logic [7:0]        p0_out,
  output logic              p0_oe,
  input  logic [7:0]        p0_in,
  output logic [7:0]        p2_out,
  output logic              p2_oe,
  input  logic [7:0]        p2_in,
  output logic              a16,
  output logic              a17,
  output logic              wclk
);
  localparam int PG_W = ADDR_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_ALE, S_STRB} st_t;

  st_t               st;
  logic [2:0]        cnt;
  logic [1:0]        kind;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wd;
  logic [PG_W-1:0]   last_pg;
  logic              last_vld;
  logic              done_q;
  logic [7:0]        rdata_q;
  logic              wclk_q;

  wire       is_wr    = (kind == 2'b10);
  wire       split    = (cfg_upper == 2'b11);
  wire       use_rd   = split && !addr[ADDR_W-1];
  wire       in_ale   = (st == S_ALE);
  wire       in_strb  = (st == S_STRB);
  wire       req_hit  = cfg_page && last_vld && (req_kind == 2'b00) &&
                        (req_addr[ADDR_W-1:8] == last_pg);
  wire       hold     = (st == S_IDLE) && done_q && req_valid && req_hit;
  wire       rtw_hold = cfg_rtw_en && !wait_n;
  wire       rd_act   = (in_strb && !is_wr) || hold;
  wire [2:0] ale_len  = {1'b0, cfg_ale_ws, 1'b1};
  wire [2:0] strb_len = {cfg_strb_ws, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      kind     <= '0;
      addr     <= '0;
      wd       <= '0;
      last_pg  <= '0;
      last_vld <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
      wclk_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wclk_q <= cfg_wclk_en ? ~wclk_q : 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          kind <= req_kind;
          addr <= req_addr;
          wd   <= req_wdata;
          if (req_hit) begin
            st  <= S_STRB;
            cnt <= strb_len;
          end else begin
            st  <= S_ALE;
            cnt <= ale_len;
          end
        end
        S_ALE: if (cnt == 3'd0) begin
          st  <= S_STRB;
          cnt <= strb_len;
        end else begin
          cnt <= cnt - 3'd1;
        end
        S_STRB: if (cnt != 3'd0) begin
          cnt <= cnt - 3'd1;
        end else if (!rtw_hold) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          if (!is_wr) rdata_q <= cfg_page ? p2_in : p0_in;
          if (cfg_page && kind == 2'b00) begin
            last_pg  <= addr[ADDR_W-1:8];
            last_vld <= 1'b1;
          end else begin
            last_vld <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (!cfg_page) last_vld <= 1'b0;
    end
  end

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign rdata  = rdata_q;
  assign ale    = in_ale;
  assign rd_n   = !(use_rd && rd_act);
  assign psen_n = !(!use_rd && rd_act);
  assign wr_n   = !(in_strb && is_wr);
  assign p0_oe  = in_ale || (in_strb && (cfg_page || is_wr));
  assign p0_out = (in_ale || cfg_page) ? addr[7:0] : wd;
  assign p2_oe  = in_ale || (in_strb && (!cfg_page || is_wr));
  assign p2_out = (in_ale || !cfg_page) ? addr[15:8] : wd;
  assign a16    = !split && addr[16];
  assign a17    = (cfg_upper == 2'b00) && addr[17];
  assign wclk   = wclk_q;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       rd_n,
  input logic       psen_n,
  input logic       wr_n,
  input logic       busy,
  input logic       done,
  input logic       p0_oe,
  input logic       p2_oe,
  input logic       wclk,
  input logic       cfg_wclk_en,
  input logic [1:0] cfg_upper
);
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && psen_n && wr_n)); // R4
  AST_ALE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> busy); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~psen_n, ~wr_n}) <= 1); // R5
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (p0_oe || p2_oe)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_WCLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wclk_en |=> !wclk); // R9
  AST_RD_PIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_upper != 2'b11) |-> rd_n); // R10
endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .psen_n(psen_n),
  .wr_n(wr_n), .busy(busy), .done(done), .p0_oe(p0_oe), .p2_oe(p2_oe),
  .wclk(wclk), .cfg_wclk_en(cfg_wclk_en), .cfg_upper(cfg_upper)
);

// File: tb/xbus_seq_bench.sv
`timescale 1ns/1ps
module xbus_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [17:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, ale, rd_n, psen_n, wr_n, p0_oe, p2_oe, a16, a17, wclk;
  logic [7:0] rdata, p0_out, p2_out;
  logic cfg_page = 1'b0, cfg_ale_ws = 1'b0, cfg_rtw_en = 1'b0, cfg_wclk_en = 1'b0;
  logic [1:0] cfg_strb_ws = 2'd0, cfg_upper = 2'b11;
  logic wait_n = 1'b1;
  logic [7:0] p0_in = 8'hA5, p2_in = 8'h3C;

  int checks = 0, errors = 0;
  int n_ale, n_rd, n_ps, n_wr, n_busy_lo;
  logic [7:0] ale_p0, ale_p2, s_p0, s_p2, got;
  logic s_oe0, s_oe2, s_a16, s_a17;

  always #2.5 clk = ~clk;

  xbus_seq u_xbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .cfg_page(cfg_page), .cfg_ale_ws(cfg_ale_ws),
    .cfg_strb_ws(cfg_strb_ws), .cfg_rtw_en(cfg_rtw_en), .cfg_wclk_en(cfg_wclk_en),
    .cfg_upper(cfg_upper), .wait_n(wait_n), .ale(ale), .rd_n(rd_n),
    .psen_n(psen_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
    .p2_out(p2_out), .p2_oe(p2_oe), .p2_in(p2_in), .a16(a16), .a17(a17), .wclk(wclk)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one bus cycle; hold_n > 0 keeps wait_n low until that many strobe clocks
  task automatic cyc(input logic [1:0] k, input logic [17:0] a, input logic [7:0] w,
                     input int hold_n, input bool_dummy_unused = 0);
    bit fa, fs;
    @(negedge clk);
    req_kind = k; req_addr = a; req_wdata = w; req_valid = 1'b1;
    wait_n = (hold_n > 0) ? 1'b0 : 1'b1;
    n_ale = 0; n_rd = 0; n_ps = 0; n_wr = 0; n_busy_lo = 0;
    fa = 1'b1; fs = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (ale) begin
        if (fa) begin ale_p0 = p0_out; ale_p2 = p2_out; fa = 1'b0; end
        n_ale++;
      end
      if (!rd_n || !psen_n || !wr_n) begin
        if (fs) begin
          s_p0 = p0_out; s_p2 = p2_out; s_oe0 = p0_oe; s_oe2 = p2_oe;
          s_a16 = a16; s_a17 = a17; fs = 1'b0;
        end
        if (!rd_n) n_rd++;
        if (!psen_n) n_ps++;
        if (!wr_n) n_wr++;
        if (hold_n > 0 && (n_rd + n_ps + n_wr) == hold_n) wait_n = 1'b1;
      end
      if (!done && !busy) n_busy_lo++;
      if (done) begin got = rdata; break; end
    end
    wait_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "ale", ale, 0);
    chk("R1", "strobes", {rd_n, psen_n, wr_n}, 3'b111);
    chk("R1", "port drive", {p0_oe, p2_oe}, 2'b00);
  endtask

  task automatic t_nonpage();
    cfg_page = 0; cfg_upper = 2'b11; cfg_ale_ws = 0; cfg_strb_ws = 0;
    cyc(2'b01, 18'h0_1234, 8'h00, 0);
    chk("R4", "ale clocks ws0", n_ale, 2);
    chk("R5", "rd clocks ws0", n_rd, 2);
    chk("R10", "no psen low-region", n_ps, 0);
    chk("R2", "ale p0", ale_p0, 8'h34);
    chk("R2", "ale p2", ale_p2, 8'h12);
    chk("R2", "read p0 released", s_oe0, 0);
    chk("R2", "read p2 addr", {s_oe2, s_p2}, {1'b1, 8'h12});
    chk("R12", "rdata from p0", got, 8'hA5);
    chk("R11", "busy gaps", n_busy_lo, 0);
    cfg_ale_ws = 1; cfg_strb_ws = 3;
    cyc(2'b10, 18'h0_5678, 8'hC3, 0);
    chk("R4", "ale clocks ws1", n_ale, 4);
    chk("R5", "wr clocks ws3", n_wr, 8);
    chk("R2", "write p0 data", {s_oe0, s_p0}, {1'b1, 8'hC3});
    chk("R2", "write p2 addr", s_p2, 8'h56);
  endtask

  task automatic t_page();
    cfg_page = 1; cfg_upper = 2'b01; cfg_ale_ws = 0; cfg_strb_ws = 0;
    cyc(2'b01, 18'h1_9ABC, 8'h00, 0);
    chk("R3", "ale p0", ale_p0, 8'hBC);
    chk("R3", "ale p2", ale_p2, 8'h9A);
    chk("R3", "strobe p0 addr", {s_oe0, s_p0}, {1'b1, 8'hBC});
    chk("R3", "read p2 released", s_oe2, 0);
    chk("R10", "mode01 psen read", n_ps, 2);
    chk("R10", "mode01 rd idle", n_rd, 0);
    chk("R10", "mode01 a16 a17", {s_a16, s_a17}, 2'b10);
    chk("R12", "rdata from p2", got, 8'h3C);
    cyc(2'b10, 18'h0_2233, 8'h77, 0);
    chk("R3", "write p2 data", {s_oe2, s_p2}, {1'b1, 8'h77});
    chk("R3", "write p0 addr", s_p0, 8'h33);
  endtask

  task automatic t_hit();
    cfg_page = 1; cfg_upper = 2'b01; cfg_strb_ws = 0;
    cyc(2'b00, 18'h0_4410, 8'h00, 0);
    chk("R6", "fetch after write misses", n_ale, 2);
    cyc(2'b00, 18'h0_4420, 8'h00, 0);
    chk("R6", "hit no ale", n_ale, 0);
    chk("R6", "hit one state", n_ps, 2);
    cfg_strb_ws = 1;
    cyc(2'b00, 18'h0_44FF, 8'h00, 0);
    chk("R6", "hit with ws1", {n_ale, n_ps}, {32'd0, 32'd4});
    cfg_strb_ws = 0;
    cyc(2'b00, 18'h0_4500, 8'h00, 0);
    chk("R6", "new page misses", n_ale, 2);
    cyc(2'b01, 18'h0_4501, 8'h00, 0);
    cyc(2'b00, 18'h0_4502, 8'h00, 0);
    chk("R6", "fetch after read misses", n_ale, 2);
  endtask

  task automatic t_burst();
    int gaps = 0, ales = 0, dones = 0;
    bit started = 0;
    cfg_page = 1; cfg_upper = 2'b01; cfg_strb_ws = 0;
    cyc(2'b01, 18'h0_0010, 8'h00, 0);
    @(negedge clk);
    req_kind = 2'b00; req_addr = 18'h0_7700; req_valid = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (ale) ales++;
      if (done && dones == 3) begin
        dones++;
        chk("R7", "psen released after last hit", psen_n, 1);
        break;
      end
      if (!psen_n) started = 1;
      else if (started) gaps++;
      if (done) begin
        dones++;
        req_addr = 18'h0_7700 + 18'(dones);
      end else if (busy && dones == 3) begin
        req_valid = 1'b0;
      end
    end
    req_valid = 1'b0;
    chk("R7", "psen gaps in burst", gaps, 0);
    chk("R7", "only first ale", ales, 2);
    chk("R11", "done count", dones, 4);
  endtask

  task automatic t_rtw();
    cfg_page = 0; cfg_upper = 2'b11; cfg_ale_ws = 0; cfg_strb_ws = 0; cfg_rtw_en = 1;
    cyc(2'b01, 18'h0_0100, 8'h00, 5);
    chk("R8", "stretched strobe", n_rd, 5);
    cfg_strb_ws = 2;
    cyc(2'b01, 18'h0_0100, 8'h00, 3);
    chk("R8", "early release", n_rd, 6);
    cfg_strb_ws = 0; cfg_rtw_en = 0;
    cyc(2'b01, 18'h0_0100, 8'h00, 99);
    chk("R8", "wait ignored when disabled", n_rd, 2);
  endtask

  task automatic t_upper();
    cfg_page = 0; cfg_strb_ws = 0; cfg_upper = 2'b00;
    cyc(2'b01, 18'h3_0011, 8'h00, 0);
    chk("R10", "mode00 pins", {s_a16, s_a17}, 2'b11);
    chk("R10", "mode00 psen", {n_ps, n_rd}, {32'd2, 32'd0});
    cfg_upper = 2'b11;
    cyc(2'b01, 18'h2_0011, 8'h00, 0);
    chk("R10", "mode11 high region psen", {n_ps, n_rd}, {32'd2, 32'd0});
    chk("R10", "mode11 pins off", {s_a16, s_a17}, 2'b00);
    cyc(2'b00, 18'h1_0011, 8'h00, 0);
    chk("R10", "mode11 low region fetch rd", {n_ps, n_rd}, {32'd0, 32'd2});
  endtask

  task automatic t_busy();
    int dn = 0;
    bit bad = 0;
    cfg_page = 0; cfg_upper = 2'b11; cfg_ale_ws = 1; cfg_strb_ws = 1;
    @(negedge clk);
    req_kind = 2'b10; req_addr = 18'h0_0042; req_wdata = 8'h5A; req_valid = 1'b1;
    @(negedge clk);
    req_kind = 2'b10; req_wdata = 8'hE1;
    for (int i = 0; i < 30; i++) begin
      if (done) begin dn++; req_valid = 1'b0; chk("R11", "busy low at done", busy, 0); break; end
      if (!busy) bad = 1;
      if (!wr_n && p0_out != 8'h5A) bad = 1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R11", "busy held, second request ignored", bad, 0);
    @(negedge clk);
    chk("R11", "done one clock", done, 0);
    chk("R11", "done seen", dn, 1);
  endtask

  task automatic t_wclk();
    logic prev;
    cfg_wclk_en = 1;
    @(negedge clk); @(negedge clk);
    prev = wclk;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9", "wclk toggles", wclk, !prev);
      prev = wclk;
    end
    cfg_wclk_en = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "wclk off", wclk, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nonpage();
    t_page();
    t_hit();
    t_burst();
    t_rtw();
    t_upper();
    t_busy();
    t_wclk();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule